// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock of an I2C master. Two programmable lengths, one for the low part of the clock and one for the high part, are counted in units of one or two system clocks. The low part is counted from the cycle in which the block starts pulling SCL down. The high part is not counted from the moment the block lets go of the line. It is counted from the moment the synchronized SCL input is seen high. A slow rise or a target that stretches the clock therefore lengthens the period and never shortens the high time.

A start request first holds SCL released for one high length, which gives the hold time between the SDA fall of a START condition and the first SCL fall. The block then clocks continuously until a stop request arrives. At that point it finishes the current high part and leaves SCL released, so the bit engine can raise SDA for the STOP condition. Two single-cycle strobes tell the bit engine when to shift the next data bit out and when to sample SDA.

Top module: `i2c_scl_pacer`

## Requirements
- R1: After reset, and from the cycle after `enable` is sampled low, `scl_drive_low`, `fall_strobe`, `mid_strobe` and `busy` are 0. A `start_req` while disabled has no effect. Taking `enable` low during a low part releases SCL at the next clock edge.
- R2: Each length is a 9-bit number. Bits 7..0 come from `low_count`/`high_count` and bit 8 comes from `low_count_ext`/`high_count_ext`. A length of 0 acts as 1.
- R3: One count unit lasts 1 clock when `div_two` is 0 and 2 clocks when `div_two` is 1. A part of length N lasts N times that unit (written N·P below).
- R4: A `start_req` sampled at edge S while idle and enabled keeps SCL released. SCL is then driven low from edge S + H·P onward.
- R5: Each low part keeps `scl_drive_low` at 1 for exactly L·P cycles. `fall_strobe` is 1 in the first of those cycles only.
- R6: High timing begins at edge R+3, where R is the first edge after which the SCL input stays high following a release. The next low part starts at R + 3 + H·P. A stretched line delays R.
- R7: `mid_strobe` pulses once per high part. It appears in the cycle that starts (floor((H−1)/2)+1)·P − 1 cycles after high timing begins, while SCL is released.
- R8: A `stop_req` during a frame ends the frame when the next high part expires. SCL stays released, `busy` returns to 0 and no further `fall_strobe` appears. A stop sampled at the same edge at which a high part expires is honoured.
- R9: Without a stop request, low and high parts alternate with the same period on every bit.
- R10: A `start_req` while a frame is running is ignored and leaves the timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; when low, SCL is released and the phase is idle |
| div_two | input | 1 | Count unit of two clocks when 1, one clock when 0 |
| low_count | input | 8 | Low length, bits 7..0 |
| low_count_ext | input | 1 | Low length, bit 8 |
| high_count | input | 8 | High length, bits 7..0 |
| high_count_ext | input | 1 | High length, bit 8 |
| start_req | input | 1 | Begin a frame with the START hold |
| stop_req | input | 1 | End the frame after the next high part |
| scl_in | input | 1 | SCL line as seen at the pad |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_strobe | output | 1 | One-cycle pulse on the first cycle of each low part |
| mid_strobe | output | 1 | One-cycle pulse in the middle of each high part |
| busy | output | 1 | A frame is in progress |

## Verification
A stop request can be sampled in the very cycle where the last count of a high part expires. In that cycle the block must choose between ending the frame and starting another low part. The bench aims the stop pulse at exactly that edge and passes only if no further fall strobe follows and SCL stays released. A second overlap is a start request arriving at the moment a high part begins. The bench drives it there and expects the scoreboard's strobe and release timings to stay unchanged.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

    localparam int LO_W  = 8;
    localparam int CNT_W = LO_W + 1;

    typedef logic [CNT_W-1:0] count_t;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_HOLD = 3'd1,
        PH_LOW  = 3'd2,
        PH_RISE = 3'd3,
        PH_HIGH = 3'd4
    } phase_e;

    typedef struct packed {
        count_t low_len;
        count_t high_len;
        logic   two;
    } pace_cfg_t;

    function automatic count_t build_count(input logic ext, input logic [LO_W-1:0] lo,
                                           input logic ext_en);
        count_t v;
        v = {ext & ext_en, lo};
        if (v == '0) v = count_t'(1);
        return v;
    endfunction

    function automatic count_t mid_point(input count_t len);
        return (len - count_t'(1)) >> 1;
    endfunction

endpackage

// File: rtl/scl_pacer_sync.sv
module scl_pacer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_stage
        logic ff;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) ff <= 1'b1;
                else     ff <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) ff <= 1'b1;
                else     ff <= g_stage[i-1].ff;
            end
        end
    end

    assign q = g_stage[STAGES-1].ff;
endmodule

// File: rtl/scl_pacer_tick.sv
module scl_pacer_tick (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic two,
    output logic tick
);
    logic half_q;

    assign tick = run && (!two || half_q);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) half_q <= 1'b0;
        else if (two)             half_q <= ~half_q;
        else                      half_q <= 1'b0;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (two && $past(two) && $past(run) && run && tick) |-> !$past(tick)); // R3
endmodule

// File: rtl/scl_pacer_count.sv
module scl_pacer_count
    import scl_pacer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   tick,
    input  count_t target,
    input  count_t mid_at,
    output logic   done,
    output logic   mid_hit
);
    count_t           cnt_q;
    logic [CNT_W:0]   next_c;

    assign next_c  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign done    = tick && (next_c >= {1'b0, target});
    assign mid_hit = tick && (cnt_q == mid_at);

    always_ff @(posedge clk) begin
        if (rst || clear)              cnt_q <= '0;
        else if (tick && cnt_q != '1)  cnt_q <= next_c[CNT_W-1:0];
    end
endmodule

// File: rtl/i2c_scl_pacer.sv
module i2c_scl_pacer
    import scl_pacer_pkg::*;
#(
    parameter bit EXT_BIT_EN  = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            div_two,
    input  logic [LO_W-1:0] low_count,
    input  logic            low_count_ext,
    input  logic [LO_W-1:0] high_count,
    input  logic            high_count_ext,
    input  logic            start_req,
    input  logic            stop_req,
    input  logic            scl_in,
    output logic            scl_drive_low,
    output logic            fall_strobe,
    output logic            mid_strobe,
    output logic            busy
);
    localparam int BLANK_W = $clog2(SYNC_STAGES + 1);

    pace_cfg_t           cfg;
    phase_e              state_q, state_d;
    logic                stop_pend_q, stop_any;
    logic [BLANK_W-1:0]  blank_q;
    logic                blank_ok;
    logic                fall_q;
    logic                scl_seen;
    logic                timed, clear, tick, done, mid_hit;
    count_t              target;

    assign cfg.low_len  = build_count(low_count_ext,  low_count,  EXT_BIT_EN);
    assign cfg.high_len = build_count(high_count_ext, high_count, EXT_BIT_EN);
    assign cfg.two      = div_two;

    scl_pacer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(scl_in), .q(scl_seen)
    );

    assign timed  = (state_q == PH_HOLD) || (state_q == PH_LOW) || (state_q == PH_HIGH);
    assign target = (state_q == PH_LOW) ? cfg.low_len : cfg.high_len;
    assign clear  = (state_d != state_q);

    scl_pacer_tick u_tick (
        .clk(clk), .rst(rst), .clear(clear), .run(timed), .two(cfg.two), .tick(tick)
    );

    scl_pacer_count u_count (
        .clk(clk), .rst(rst), .clear(clear), .tick(tick), .target(target),
        .mid_at(mid_point(cfg.high_len)), .done(done), .mid_hit(mid_hit)
    );

    assign stop_any = stop_pend_q || stop_req;
    assign blank_ok = (blank_q >= BLANK_W'(SYNC_STAGES));

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = PH_IDLE;
        end else begin
            unique case (state_q)
                PH_IDLE: if (start_req)           state_d = PH_HOLD;
                PH_HOLD: if (done)                state_d = stop_any ? PH_IDLE : PH_LOW;
                PH_LOW:  if (done)                state_d = PH_RISE;
                PH_RISE: if (blank_ok && scl_seen) state_d = PH_HIGH;
                PH_HIGH: if (done)                state_d = stop_any ? PH_IDLE : PH_LOW;
                default:                          state_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= PH_IDLE;
            stop_pend_q <= 1'b0;
            blank_q     <= '0;
            fall_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            fall_q  <= (state_d == PH_LOW) && (state_q != PH_LOW);
            if (state_d == PH_IDLE)
                stop_pend_q <= 1'b0;
            else if (stop_req && state_q != PH_IDLE)
                stop_pend_q <= 1'b1;
            if (clear)
                blank_q <= '0;
            else if (state_q == PH_RISE && !blank_ok)
                blank_q <= blank_q + BLANK_W'(1);
        end
    end

    assign scl_drive_low = (state_q == PH_LOW);
    assign fall_strobe   = fall_q;
    assign mid_strobe    = (state_q == PH_HIGH) && mid_hit;
    assign busy          = (state_q != PH_IDLE);

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> (!scl_drive_low && !fall_strobe && !mid_strobe && !busy)); // R1
    AST_FALL_OPENS_LOW: assert property (@(posedge clk) disable iff (rst)
        fall_strobe |-> (scl_drive_low && !$past(scl_drive_low))); // R5
    AST_MID_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        mid_strobe |-> (!scl_drive_low && !fall_strobe)); // R7
    AST_HIGH_AFTER_SEEN: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_HIGH && $past(state_q) == PH_RISE) |-> $past(scl_seen)); // R6
    AST_END_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_IDLE && $past(state_q) == PH_HIGH && $past(enable))
            |-> $past(stop_pend_q || stop_req)); // R8
endmodule

// File: tb/i2c_scl_pacer_tb_top.sv
module i2c_scl_pacer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       div_two = 1'b0;
    logic [7:0] low_count = 8'd4;
    logic       low_count_ext = 1'b0;
    logic [7:0] high_count = 8'd4;
    logic       high_count_ext = 1'b0;
    logic       start_req = 1'b0;
    logic       stop_req = 1'b0;
    logic       stretch_q = 1'b0;
    logic       scl_in;
    logic       scl_drive_low, fall_strobe, mid_strobe, busy;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int stretch_k = 0;
    int stretch_n = 0;
    logic prev_low = 1'b0;

    typedef struct { int kind; int at; string tag; } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign scl_in = !(scl_drive_low || stretch_q);

    i2c_scl_pacer dut_i (
        .clk(clk), .rst(rst), .enable(enable), .div_two(div_two),
        .low_count(low_count), .low_count_ext(low_count_ext),
        .high_count(high_count), .high_count_ext(high_count_ext),
        .start_req(start_req), .stop_req(stop_req), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .fall_strobe(fall_strobe),
        .mid_strobe(mid_strobe), .busy(busy)
    );

    function automatic string kname(input int k);
        return (k == 0) ? "fall" : (k == 1) ? "release" : "mid";
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push_ev(input int kind, input int at, input string tag);
        exp_t e;
        e.kind = kind; e.at = at; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic match_ev(input int k);
        while (sb_q.size() > 0 && sb_q[0].at < cyc) begin
            chk(1'b0, sb_q[0].tag, -1, sb_q[0].at, {"missing ", kname(sb_q[0].kind), " at cycle"});
            void'(sb_q.pop_front());
        end
        if (sb_q.size() > 0 && sb_q[0].at == cyc && sb_q[0].kind == k) begin
            chk(1'b1, sb_q[0].tag, cyc, cyc, "event");
            void'(sb_q.pop_front());
        end else if (sb_q.size() > 0) begin
            chk(1'b0, sb_q[0].tag, cyc, sb_q[0].at, {"unexpected ", kname(k), " at cycle"});
        end else begin
            chk(1'b0, "R1", cyc, -1, {"unexpected ", kname(k), " with nothing expected, cycle"});
        end
    endtask

    task automatic drain(input string req);
        while (sb_q.size() > 0) begin
            chk(1'b0, sb_q[0].tag, -1, sb_q[0].at, {"missing ", kname(sb_q[0].kind), " at cycle"});
            void'(sb_q.pop_front());
        end
        chk(scl_drive_low == 1'b0, req, scl_drive_low, 0, "scl released after frame");
        chk(busy == 1'b0, req, busy, 0, "busy after frame");
    endtask

    // monitor: compare strobes and releases against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (fall_strobe) match_ev(0);
                if (prev_low && !scl_drive_low) match_ev(1);
                if (mid_strobe) match_ev(2);
            end
            prev_low = scl_drive_low;
        end
    end

    // target model: stretches SCL for stretch_k cycles after each release
    initial begin
        forever begin
            @(negedge clk);
            if (scl_drive_low) begin
                stretch_n = 0;
                stretch_q = (stretch_k > 0);
            end else if (stretch_q) begin
                stretch_n++;
                if (stretch_n >= stretch_k) stretch_q = 1'b0;
            end
        end
    end

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic run_frame(input int lo_len, input int hi_len, input bit two, input int nbits,
                             input int stretch, input bit stop_same, input bit restart,
                             input string tag);
        int p, l, h, d, s, f, e, hn, fn, h1, stop_at;
        low_count      = lo_len[7:0];
        low_count_ext  = lo_len[8];
        high_count     = hi_len[7:0];
        high_count_ext = hi_len[8];
        div_two        = two;
        stretch_k      = stretch;
        @(negedge clk);
        p = two ? 2 : 1;
        l = (lo_len == 0) ? 1 : lo_len;
        h = (hi_len == 0) ? 1 : hi_len;
        d = (stretch > 0) ? stretch - 1 : 0;
        s = cyc + 1;
        f = s + h * p;
        fn = 0; h1 = 0;
        for (int i = 1; i <= nbits; i++) begin
            push_ev(0, f, (i == 1) ? {"R4/", tag} : {"R6/", tag});
            if (i == nbits) fn = f;
            e = f + l * p;
            push_ev(1, e, {"R5/", tag});
            hn = e + d + 3;
            if (i == 1) h1 = hn;
            push_ev(2, hn + ((h - 1) / 2 + 1) * p - 1, {"R7/", tag});
            f = hn + h * p;
        end
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        if (restart) begin
            wait_cyc(h1 - 1);
            start_req = 1'b1;
            @(negedge clk);
            start_req = 1'b0;
        end
        stop_at = stop_same ? f - 1 : fn;
        wait_cyc(stop_at);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        wait_cyc(f + 8);
        drain({"R8/", tag});
        stretch_k = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int f;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R1", scl_drive_low, 0, "scl after reset");
        chk(busy == 1'b0, "R1", busy, 0, "busy after reset");
        chk(fall_strobe == 1'b0 && mid_strobe == 1'b0, "R1", fall_strobe | mid_strobe, 0, "strobes after reset");

        // R1: start ignored while disabled
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R1", busy, 0, "busy after start while disabled");
        chk(scl_drive_low == 1'b0, "R1", scl_drive_low, 0, "scl after start while disabled");

        enable = 1'b1;
        @(negedge clk);
        run_frame(4, 3, 1'b0, 3, 0, 1'b0, 1'b0, "R9");
        run_frame(5, 4, 1'b1, 2, 0, 1'b0, 1'b0, "R3");
        run_frame(3, 5, 1'b0, 2, 6, 1'b0, 1'b0, "R6_stretch");
        run_frame(9'h105, 9'h102, 1'b0, 1, 0, 1'b0, 1'b0, "R2_wide");
        run_frame(0, 0, 1'b0, 3, 0, 1'b0, 1'b0, "R2_zero");
        run_frame(4, 6, 1'b0, 2, 0, 1'b1, 1'b0, "R8_same_cycle");
        run_frame(4, 4, 1'b1, 3, 0, 1'b0, 1'b1, "R10");
        run_frame(5, 7, 1'b1, 1, 3, 1'b1, 1'b0, "R8_div2");

        // R1: disable during a low part releases SCL at the next edge
        low_count = 8'd20; low_count_ext = 1'b0;
        high_count = 8'd10; high_count_ext = 1'b0;
        div_two = 1'b0;
        @(negedge clk);
        f = cyc + 1 + 10;
        push_ev(0, f, "R4/R1_disable");
        push_ev(1, f + 6, "R1");
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        wait_cyc(f + 5);
        enable = 1'b0;
        wait_cyc(f + 30);
        drain("R1");
        enable = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule